// File: doc/BRIEF.md
# UART Modem Handshake Control and Status

This block is the modem-handshake slice of a 16550-class serial port. A CPU-side register port gives access to two byte-wide registers. The control register drives four active-low handshake outputs: data-terminal-ready, request-to-send and two general-purpose outputs. The status register reports the present levels of four active-low modem inputs, which are clear-to-send, data-set-ready, ring indicator and carrier detect. Next to each level it holds a sticky change flag.

Every modem input is resynchronised through a flop chain before edge detection. Reading the status register clears the change flags. A change that lands in the same cycle as that read is kept. When the modem-status interrupt enable is high, any set change flag raises the interrupt request.

A loopback mode parks all four outputs at their inactive (high) level. In that mode the status inputs are fed internally from the control bits, so software can test the handshake path without a modem attached. Master reset is active high and returns the block to its idle state.

Top module: `uart_modem_ctl`

## Requirements
- R1: Register select 0 is the control register. Writing it stores bits 4..0, and a read returns those five bits with bits 7..5 as zero. Writing with select 1 changes neither register.
- R2: The outputs follow the control bits active-low: dtr_n = !bit0, rts_n = !bit1, out1_n = !bit2, out2_n = !bit3. Each output changes on the clock edge that takes the write.
- R3: While control bit 4 (loopback) is set, all four outputs are high, whatever bits 3..0 hold.
- R4: In loopback the asserted levels come from the control bits: CTS from bit1, DSR from bit0, RI from bit2 and DCD from bit3. The external modem inputs then have no effect on the status register.
- R5: Outside loopback, status bits 4, 5, 6 and 7 read as the inverted levels of cts_n, dsr_n, ri_n and dcd_n. A new input level is visible two clock edges after it is applied (two-flop synchroniser).
- R6: Status bits 0, 1 and 3 are set by any change in the asserted level of CTS, DSR and DCD respectively. Bit 2 is set only when RI goes from asserted to deasserted (ri_n low to high). A set flag stays set until a status read.
- R7: A status read (cpu_rd with select 1) clears bits 3..0 on the following edge. A change detected on that same edge sets its flag anyway.
- R8: irq is high exactly when msi_en is high and at least one of status bits 3..0 is set.
- R9: While rst is high, the control register and change flags clear, all four outputs go high and irq goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Master reset, active high, synchronous |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe; a status read clears change flags |
| reg_sel | input | 1 | 0 selects the control register, 1 the status register |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data of the selected register (combinational) |
| msi_en | input | 1 | Modem-status interrupt enable |
| cts_n | input | 1 | Clear to send, active low, asynchronous |
| dsr_n | input | 1 | Data set ready, active low, asynchronous |
| ri_n | input | 1 | Ring indicator, active low, asynchronous |
| dcd_n | input | 1 | Carrier detect, active low, asynchronous |
| dtr_n | output | 1 | Data terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |
| out1_n | output | 1 | General-purpose output 1, active low |
| out2_n | output | 1 | General-purpose output 2, active low |
| irq | output | 1 | Modem-status interrupt request, active high |

## Verification
The assertions assume that a status read and a control write never share a cycle. They also assume reg_sel is valid whenever a strobe is high, and that the modem inputs are inactive while rst is high, so the synchroniser's reset value matches the pins. The stimulus keeps to these rules: every register access is a one-cycle strobe driven on the falling edge. Inputs change only between accesses, apart from the deliberate case where a change is timed to reach the detector on the very edge of a status read.

// File: rtl/uart_modem_pkg.sv
package uart_modem_pkg;

    localparam int DATA_W    = 8;
    localparam int NUM_LINES = 4;

    // index of each modem line inside the 4-bit level / change vectors
    localparam int LN_CTS = 0;
    localparam int LN_DSR = 1;
    localparam int LN_RI  = 2;
    localparam int LN_DCD = 3;

    typedef struct packed {
        logic loop;
        logic out2;
        logic out1;
        logic rts;
        logic dtr;
    } ctl_bits_t;

    typedef struct packed {
        logic [NUM_LINES-1:0] prev;
        logic [NUM_LINES-1:0] delta;
    } stat_state_t;

endpackage

// File: rtl/modem_input_sync.sv
module modem_input_sync #(
    parameter int         WIDTH   = 4,
    parameter int         STAGES  = 2,
    parameter logic       RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= {WIDTH{RST_VAL}};
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/modem_ctl_reg.sv
module modem_ctl_reg
    import uart_modem_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output ctl_bits_t         ctl,
    output logic              dtr_n,
    output logic              rts_n,
    output logic              out1_n,
    output logic              out2_n
);

    ctl_bits_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            ctl_d = ctl_bits_t'(wdata[$bits(ctl_bits_t)-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    assign ctl    = ctl_q;
    // loopback parks every output at its inactive level
    assign dtr_n  = ~ctl_q.dtr  | ctl_q.loop;
    assign rts_n  = ~ctl_q.rts  | ctl_q.loop;
    assign out1_n = ~ctl_q.out1 | ctl_q.loop;
    assign out2_n = ~ctl_q.out2 | ctl_q.loop;

endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
    import uart_modem_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] lvl_n,
    input  ctl_bits_t            ctl,
    input  logic                 rd_clr,
    input  logic                 msi_en,
    output logic [DATA_W-1:0]    msr,
    output logic [NUM_LINES-1:0] delta,
    output logic [NUM_LINES-1:0] chg,
    output logic                 irq
);

    stat_state_t          st_d, st_q;
    logic [NUM_LINES-1:0] cur;
    logic [NUM_LINES-1:0] loop_lvl;

    always_comb begin
        loop_lvl         = '0;
        loop_lvl[LN_CTS] = ctl.rts;
        loop_lvl[LN_DSR] = ctl.dtr;
        loop_lvl[LN_RI]  = ctl.out1;
        loop_lvl[LN_DCD] = ctl.out2;
        cur = ctl.loop ? loop_lvl : ~lvl_n;
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_edge
        if (g == LN_RI) begin : g_trail
            assign chg[g] = st_q.prev[g] & ~cur[g];
        end else begin : g_any
            assign chg[g] = st_q.prev[g] ^ cur[g];
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.prev  = cur;
        // set wins over the read-clear on the same edge
        st_d.delta = (rd_clr ? '0 : st_q.delta) | chg;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign delta = st_q.delta;
    assign msr   = {cur, st_q.delta};
    assign irq   = msi_en & (|st_q.delta);

endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
    import uart_modem_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              msi_en,
    input  logic              cts_n,
    input  logic              dsr_n,
    input  logic              ri_n,
    input  logic              dcd_n,
    output logic              dtr_n,
    output logic              rts_n,
    output logic              out1_n,
    output logic              out2_n,
    output logic              irq
);

    localparam int CTL_W = $bits(ctl_bits_t);

    ctl_bits_t            ctl;
    logic [NUM_LINES-1:0] raw_n;
    logic [NUM_LINES-1:0] sync_n;
    logic [DATA_W-1:0]    msr;
    logic [NUM_LINES-1:0] delta_w;
    logic [NUM_LINES-1:0] chg_w;

    always_comb begin
        raw_n         = '1;
        raw_n[LN_CTS] = cts_n;
        raw_n[LN_DSR] = dsr_n;
        raw_n[LN_RI]  = ri_n;
        raw_n[LN_DCD] = dcd_n;
    end

    modem_input_sync #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_STAGES),
        .RST_VAL(1'b1)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .din (raw_n),
        .dout(sync_n)
    );

    modem_ctl_reg u_ctl (
        .clk   (clk),
        .rst   (rst),
        .wr_en (cpu_wr & ~reg_sel),
        .wdata (cpu_wdata),
        .ctl   (ctl),
        .dtr_n (dtr_n),
        .rts_n (rts_n),
        .out1_n(out1_n),
        .out2_n(out2_n)
    );

    modem_status_reg u_stat (
        .clk   (clk),
        .rst   (rst),
        .lvl_n (sync_n),
        .ctl   (ctl),
        .rd_clr(cpu_rd & reg_sel),
        .msi_en(msi_en),
        .msr   (msr),
        .delta (delta_w),
        .chg   (chg_w),
        .irq   (irq)
    );

    always_comb begin
        if (reg_sel) cpu_rdata = msr;
        else         cpu_rdata = {{(DATA_W-CTL_W){1'b0}}, ctl};
    end

endmodule

// File: rtl/uart_modem_ctl_checker.sv
module uart_modem_ctl_checker (
    input logic       clk,
    input logic       rst,
    input logic       cpu_wr,
    input logic       cpu_rd,
    input logic       reg_sel,
    input logic [7:0] cpu_wdata,
    input logic       msi_en,
    input logic       dtr_n,
    input logic       rts_n,
    input logic       out1_n,
    input logic       out2_n,
    input logic       irq,
    input logic [3:0] delta_w,
    input logic [3:0] chg_w
);

    // R2: outputs take the written bits on the next edge when not in loopback
    p_ctl_follow_r2: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && !reg_sel && !cpu_wdata[4]) |=>
            (dtr_n == !$past(cpu_wdata[0]) && rts_n == !$past(cpu_wdata[1]) &&
             out1_n == !$past(cpu_wdata[2]) && out2_n == !$past(cpu_wdata[3])));

    // R3: a loopback write parks all outputs high
    p_loop_park_r3: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && !reg_sel && cpu_wdata[4]) |=>
            (dtr_n && rts_n && out1_n && out2_n));

    // R6: a set flag survives any cycle without a status read
    p_delta_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!(cpu_rd && reg_sel) && (delta_w != 4'd0)) |=> (delta_w != 4'd0));

    // R7: a read with no new change leaves no flag behind
    p_read_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && reg_sel && (chg_w == 4'd0)) |=> (delta_w == 4'd0));

    // R7: a change on the read edge still sets its flag
    p_read_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && reg_sel && (chg_w != 4'd0)) |=> (delta_w != 4'd0));

    // R8: no request while the enable is low
    p_irq_gate_r8: assert property (@(posedge clk) disable iff (rst)
        !msi_en |-> !irq);

    // R9: the cycle after reset shows the idle outputs
    p_reset_idle_r9: assert property (@(posedge clk)
        rst |=> (dtr_n && rts_n && out1_n && out2_n && !irq));

endmodule

bind uart_modem_ctl uart_modem_ctl_checker chk_i (
    .clk      (clk),
    .rst      (rst),
    .cpu_wr   (cpu_wr),
    .cpu_rd   (cpu_rd),
    .reg_sel  (reg_sel),
    .cpu_wdata(cpu_wdata),
    .msi_en   (msi_en),
    .dtr_n    (dtr_n),
    .rts_n    (rts_n),
    .out1_n   (out1_n),
    .out2_n   (out2_n),
    .irq      (irq),
    .delta_w  (delta_w),
    .chg_w    (chg_w)
);

// File: tb/uart_modem_ctl_tb_top.sv
module uart_modem_ctl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_wr = 1'b0, cpu_rd = 1'b0, reg_sel = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       msi_en = 1'b1;
    logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
    logic       dtr_n, rts_n, out1_n, out2_n, irq;

    int  n_vec  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    uart_modem_ctl dut_i (
        .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .reg_sel(reg_sel),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .msi_en(msi_en),
        .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
        .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n), .irq(irq)
    );

    // kind[17:16]: 0 write control, check pins {out2_n,out1_n,rts_n,dtr_n}
    //              1 drive inputs {dcd_n,ri_n,dsr_n,cts_n}, check irq
    //              2 read status  3 read control
    localparam int NV = 24;
    localparam logic [17:0] VEC [NV] = '{
        {2'd2, 8'h00, 8'h00},
        {2'd0, 8'h0F, 8'h00},
        {2'd3, 8'h00, 8'h0F},
        {2'd0, 8'hFF, 8'h0F},
        {2'd3, 8'h00, 8'h1F},
        {2'd2, 8'h00, 8'hFB},
        {2'd2, 8'h00, 8'hF0},
        {2'd0, 8'h1E, 8'h0F},
        {2'd2, 8'h00, 8'hD2},
        {2'd0, 8'h1A, 8'h0F},
        {2'd2, 8'h00, 8'h94},
        {2'd0, 8'h00, 8'h0F},
        {2'd2, 8'h00, 8'h09},
        {2'd1, 8'h0E, 8'h01},
        {2'd2, 8'h00, 8'h11},
        {2'd1, 8'h0E, 8'h00},
        {2'd1, 8'h0B, 8'h01},
        {2'd2, 8'h00, 8'h41},
        {2'd1, 8'h0F, 8'h01},
        {2'd2, 8'h00, 8'h04},
        {2'd0, 8'h05, 8'h0A},
        {2'd1, 8'h07, 8'h01},
        {2'd2, 8'h00, 8'h88},
        {2'd1, 8'h0F, 8'h01}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pins();
        return {4'h0, out2_n, out1_n, rts_n, dtr_n};
    endfunction

    task automatic wr_reg(input logic sel, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; reg_sel = sel; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic sel, output logic [7:0] d);
        repeat (2) @(negedge clk);
        cpu_rd = 1'b1; reg_sel = sel;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic set_in(input logic [3:0] v);
        @(negedge clk);
        {dcd_n, ri_n, dsr_n, cts_n} = v;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        check("R9 pins", pins(), 8'h0F);
        check("R9 irq", {7'd0, irq}, 8'h00);
        rd_reg(1'b0, r); check("R9 ctl", r, 8'h00);
        rd_reg(1'b1, r); check("R9 status", r, 8'h00);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][17:16])
                2'd0: begin wr_reg(1'b0, VEC[i][15:8]); check("R2/R3 pins", pins(), VEC[i][7:0]); end
                2'd1: begin set_in(VEC[i][11:8]); check("R8 irq", {7'd0, irq}, VEC[i][7:0]); end
                2'd2: begin rd_reg(1'b1, r); check("R4/R6 status", r, VEC[i][7:0]); end
                default: begin rd_reg(1'b0, r); check("R1 ctl", r, VEC[i][7:0]); end
            endcase
        end
        rd_reg(1'b1, r); check("R6 dcd release", r, 8'h08);

        // R8: enable gating
        msi_en = 1'b0;
        set_in(4'b1101);
        check("R8 gated", {7'd0, irq}, 8'h00);
        msi_en = 1'b1;
        #1 check("R8 enabled", {7'd0, irq}, 8'h01);
        rd_reg(1'b1, r); check("R6 dsr", r, 8'h22);
        #1 check("R8 irq after read", {7'd0, irq}, 8'h00);

        // R7: change reaching the detector on the read edge
        @(negedge clk); dsr_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        cpu_rd = 1'b1; reg_sel = 1'b1;
        #1 check("R7 collide read", cpu_rdata, 8'h00);
        @(negedge clk); cpu_rd = 1'b0;
        rd_reg(1'b1, r); check("R7 flag kept", r, 8'h02);

        // R1: status write ignored
        wr_reg(1'b1, 8'hFF);
        rd_reg(1'b1, r); check("R1 status write", r, 8'h00);
        rd_reg(1'b0, r); check("R1 ctl unchanged", r, 8'h05);

        // R4: external inputs ignored in loopback
        wr_reg(1'b0, 8'h10);
        rd_reg(1'b1, r); check("R4 enter", r, 8'h00);
        set_in(4'b1110);
        rd_reg(1'b1, r); check("R4 ext ignored", r, 8'h00);
        check("R4 irq", {7'd0, irq}, 8'h00);
        wr_reg(1'b0, 8'h00);
        rd_reg(1'b1, r); check("R4 exit", r, 8'h11);

        // R5: two-edge synchroniser latency
        @(negedge clk); reg_sel = 1'b1; cts_n = 1'b1;
        @(negedge clk); check("R5 one edge", {7'd0, cpu_rdata[4]}, 8'h01);
        @(negedge clk); check("R5 two edges", {7'd0, cpu_rdata[4]}, 8'h00);

        // R9: reset mid-operation
        wr_reg(1'b0, 8'h0F);
        check("R2 all on", pins(), 8'h00);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R9 pins", pins(), 8'h0F);
        check("R9 irq", {7'd0, irq}, 8'h00);
        rd_reg(1'b0, r); check("R9 ctl", r, 8'h00);
        rd_reg(1'b1, r); check("R9 status", r, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule